// File: doc/BRIEF.md
# Parallel Panel Bus Strobe Sequencer

This block runs single accesses on an 8080-style parallel bus that connects a host to a smart display panel. A request picks a chip-select channel and one of three access kinds: a command write, a data (parameter) write or a read. The block then steps a tick counter and produces chip select, write strobe, read strobe, the command/data select line and the write data bus. Each edge of each strobe is placed at a tick count taken from the chosen channel's timing words.

There are two channels, and each has its own on/off timing word, cycle timing word and configuration word. At acceptance the chosen channel's words are copied, so an access always finishes with the settings it started with. A configuration bit can halve the tick rate. Four further bits set the active level of each bus control line. For a read, the input bus is sampled once at the programmed access tick, and a one-clock valid pulse marks the end of the read cycle.

Top module: `pbs_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `rd_valid` are 0. `bus_cs`, `bus_we`, `bus_re` and `bus_dc` are all 1, which is the idle level for an all-zero polarity setting.
- R2: A request is taken on a clock edge where `req_valid` is 1, `busy` is 0, `cs_sel` is 1 (channel 0) or 2 (channel 1) and `req_kind` is 0 (command write), 1 (data write) or 2 (read). A request with `cs_sel` of 0 or 3, a request with `req_kind` 3, and any request made while `busy` is 1 start no access and leave the latched write data unchanged. `busy` is 1 from the clock after acceptance.
- R3: When configuration bit 4 is 1, the tick counter advances once every two clocks. When it is 0, the counter advances on every clock.
- R4: The on/off word places CS-on in bits [3:0], CS-off in [9:4], WE-on in [13:10], WE-off in [19:14], RE-on in [23:20] and RE-off in [29:24]. Chip select is active while the tick count t satisfies CS-on <= t < max(CS-off, CS-on + CS-min-width).
- R5: In write accesses the write strobe is active while WE-on <= t < WE-off and the read strobe stays inactive. In read accesses the read strobe is active while RE-on <= t < RE-off and the write strobe stays inactive.
- R6: The command/data line is in its command state for the whole of a command write. It is in its data state during data writes, during reads and while idle.
- R7: Configuration bits 16, 17, 18 and 19 set the active level of the command/data line (command state), read strobe, write strobe and chip select. A bit value of 1 means the line is high when active, and 0 means it is low when active. The levels come from the channel of the most recent accepted access.
- R8: The cycle word places the write cycle length in bits [5:0], the read cycle length in [11:6], the CS minimum width in [17:12] and the access time in [27:22]. An access lasts E ticks, where E = max(cycle length for its kind, CS release tick), and for reads E is also at least access time + 1. `busy` falls on the edge that completes tick E.
- R9: A read latches `bus_din` into `rd_data` on the tick that ends with the count equal to the access time. `rd_valid` is 1 for exactly the one clock after the read's `busy` falls, and `rd_data` then holds until the next read.
- R10: An access uses the timing and configuration words of the channel named by `cs_sel` at acceptance. Changes to any channel word while the access runs have no effect on it.
- R11: During a write access `bus_oe` is 1 and `bus_dout` holds the accepted `req_wdata` unchanged. During reads and while idle `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_time_ch0 | input | 32 | Channel 0 strobe on/off tick word |
| cyc_time_ch0 | input | 32 | Channel 0 cycle, CS width and access tick word |
| cfg_ch0 | input | 32 | Channel 0 tick rate and polarity bits |
| on_time_ch1 | input | 32 | Channel 1 strobe on/off tick word |
| cyc_time_ch1 | input | 32 | Channel 1 cycle, CS width and access tick word |
| cfg_ch1 | input | 32 | Channel 1 tick rate and polarity bits |
| cs_sel | input | 2 | Channel select: 1 = channel 0, 2 = channel 1 |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 command write, 1 data write, 2 read |
| req_wdata | input | DW | Write data for the access |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-clock pulse at the end of a read |
| rd_data | output | DW | Data captured by the last read |
| bus_cs | output | 1 | Chip select pin |
| bus_we | output | 1 | Write strobe pin |
| bus_re | output | 1 | Read strobe pin |
| bus_dc | output | 1 | Command/data select pin |
| bus_dout | output | DW | Data driven to the panel |
| bus_oe | output | 1 | Output enable for the data bus |
| bus_din | input | DW | Data returned by the panel |

## Verification
The hardest case to reach is a read whose access time falls at or after its programmed read cycle length, so that the access tick, and not the cycle length, sets when `busy` falls. A second hard case is a read at half tick rate, where the sample lands on the second clock of a tick. The bench gets there by loading channel 1 with an access time beyond its read length and half-rate ticks. It then changes `bus_din` on every clock, so the captured value shows exactly which clock the sample came from. A further sequence holds a new request with different data and drives altered channel words throughout a running access. This shows that neither the request nor the altered words reach the bus.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // tick counter width: covers 15 + 63 for the CS release tick
  localparam int TK_W = 7;

  typedef enum logic [1:0] {
    ACC_CMD  = 2'd0,
    ACC_DATA = 2'd1,
    ACC_READ = 2'd2,
    ACC_RSVD = 2'd3
  } acc_kind_e;

  // decoded per-channel settings; pol = {cs, we, re, dc}
  typedef struct packed {
    logic [3:0] cs_on;
    logic [5:0] cs_off;
    logic [3:0] we_on;
    logic [5:0] we_off;
    logic [3:0] re_on;
    logic [5:0] re_off;
    logic [5:0] wr_len;
    logic [5:0] rd_len;
    logic [5:0] cs_min;
    logic [5:0] acc_t;
    logic       half_rate;
    logic [3:0] pol;
  } tset_t;

  function automatic logic [TK_W-1:0] tk_max(input logic [TK_W-1:0] a,
                                             input logic [TK_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // tick at which chip select is released
  function automatic logic [TK_W-1:0] cs_release(input tset_t s);
    return tk_max(TK_W'(s.cs_off), TK_W'(s.cs_on) + TK_W'(s.cs_min));
  endfunction

  // total ticks of one access
  function automatic logic [TK_W-1:0] cycle_ticks(input tset_t s, input logic is_rd);
    logic [TK_W-1:0] len;
    len = is_rd ? TK_W'(s.rd_len) : TK_W'(s.wr_len);
    len = tk_max(len, cs_release(s));
    if (is_rd) len = tk_max(len, TK_W'(s.acc_t) + TK_W'(1));
    return len;
  endfunction

endpackage

// File: rtl/pbs_chan_sel.sv
module pbs_chan_sel
  import pbs_pkg::*;
#(
  parameter int NCH = 2,
  localparam int SEL_W = $clog2(NCH + 1)
) (
  input  logic [31:0]      on_w  [NCH],
  input  logic [31:0]      cyc_w [NCH],
  input  logic [31:0]      cfg_w [NCH],
  input  logic [SEL_W-1:0] sel,
  output tset_t            set_o,
  output logic             sel_ok
);

  tset_t dec [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign dec[c] = {on_w[c][3:0],   on_w[c][9:4],
                     on_w[c][13:10], on_w[c][19:14],
                     on_w[c][23:20], on_w[c][29:24],
                     cyc_w[c][5:0],  cyc_w[c][11:6],
                     cyc_w[c][17:12], cyc_w[c][27:22],
                     cfg_w[c][4],    cfg_w[c][19:16]};
    logic ch_unused;
    assign ch_unused = ^{on_w[c][31:30], cyc_w[c][21:18], cyc_w[c][31:28],
                         cfg_w[c][3:0], cfg_w[c][15:5], cfg_w[c][31:20]};
  end

  always_comb begin
    set_o = dec[0];
    for (int c = 0; c < NCH; c++) begin
      if (sel == SEL_W'(c + 1)) set_o = dec[c];
    end
  end

  assign sel_ok = (sel != '0) && (sel <= SEL_W'(NCH));

endmodule

// File: rtl/pbs_tick_gen.sv
module pbs_tick_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic half_rate,
  output logic tick
);

  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= 1'b0;
    else if (restart) phase_q <= 1'b0;
    else if (run)     phase_q <= ~phase_q;
  end

  assign tick = run && (!half_rate || phase_q);

endmodule

// File: rtl/pbs_strobe_gen.sv
module pbs_strobe_gen
  import pbs_pkg::*;
(
  input  logic            busy,
  input  logic [TK_W-1:0] tcnt,
  input  acc_kind_e       kind,
  input  tset_t           tset,
  output logic            cs_act,
  output logic            we_act,
  output logic            re_act,
  output logic            dc_act,
  output logic [3:0]      pins   // {cs, we, re, dc}
);

  logic       is_wr;
  logic [3:0] act_vec;

  assign is_wr  = (kind == ACC_CMD) || (kind == ACC_DATA);
  assign cs_act = busy && (tcnt >= TK_W'(tset.cs_on)) && (tcnt < cs_release(tset));
  assign we_act = busy && is_wr && (tcnt >= TK_W'(tset.we_on)) && (tcnt < TK_W'(tset.we_off));
  assign re_act = busy && !is_wr && (tcnt >= TK_W'(tset.re_on)) && (tcnt < TK_W'(tset.re_off));
  assign dc_act = busy && (kind == ACC_CMD);

  assign act_vec = {cs_act, we_act, re_act, dc_act};

  for (genvar i = 0; i < 4; i++) begin : g_pol
    assign pins[i] = tset.pol[i] ? act_vec[i] : ~act_vec[i];
  end

endmodule

// File: rtl/pbs_strobe_seq.sv
module pbs_strobe_seq
  import pbs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   on_time_ch0,
  input  logic [31:0]   cyc_time_ch0,
  input  logic [31:0]   cfg_ch0,
  input  logic [31:0]   on_time_ch1,
  input  logic [31:0]   cyc_time_ch1,
  input  logic [31:0]   cfg_ch1,
  input  logic [1:0]    cs_sel,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          bus_cs,
  output logic          bus_we,
  output logic          bus_re,
  output logic          bus_dc,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_din
);

  localparam int NCH = 2;

  logic [31:0] on_arr  [NCH];
  logic [31:0] cyc_arr [NCH];
  logic [31:0] cfg_arr [NCH];

  assign on_arr[0]  = on_time_ch0;
  assign on_arr[1]  = on_time_ch1;
  assign cyc_arr[0] = cyc_time_ch0;
  assign cyc_arr[1] = cyc_time_ch1;
  assign cfg_arr[0] = cfg_ch0;
  assign cfg_arr[1] = cfg_ch1;

  tset_t           sel_set, cur_set;
  logic            sel_ok;
  logic            busy_q, rd_valid_q;
  logic [TK_W-1:0] tcnt_q, end_q;
  acc_kind_e       kind_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  // named events
  logic accept_ev, tick_ev, capture_ev, last_tick_ev;
  logic cs_act, we_act, re_act, dc_act;
  logic [3:0] pin_vec;

  pbs_chan_sel #(.NCH(NCH)) u_sel (
    .on_w   (on_arr),
    .cyc_w  (cyc_arr),
    .cfg_w  (cfg_arr),
    .sel    (cs_sel),
    .set_o  (sel_set),
    .sel_ok (sel_ok)
  );

  assign accept_ev = req_valid && !busy_q && sel_ok && (req_kind != ACC_RSVD);

  pbs_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept_ev),
    .run       (busy_q),
    .half_rate (cur_set.half_rate),
    .tick      (tick_ev)
  );

  assign capture_ev   = tick_ev && (kind_q == ACC_READ) && (tcnt_q == TK_W'(cur_set.acc_t));
  assign last_tick_ev = tick_ev && ((tcnt_q + TK_W'(1)) >= end_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      tcnt_q     <= '0;
      end_q      <= '0;
      kind_q     <= ACC_DATA;
      wdata_q    <= '0;
      rdata_q    <= '0;
      cur_set    <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (accept_ev) begin
        busy_q  <= 1'b1;
        tcnt_q  <= '0;
        kind_q  <= acc_kind_e'(req_kind);
        wdata_q <= req_wdata;
        cur_set <= sel_set;
        end_q   <= cycle_ticks(sel_set, req_kind == ACC_READ);
      end else if (tick_ev) begin
        if (capture_ev) rdata_q <= bus_din;
        if (last_tick_ev) begin
          busy_q     <= 1'b0;
          tcnt_q     <= '0;
          rd_valid_q <= (kind_q == ACC_READ);
        end else begin
          tcnt_q <= tcnt_q + TK_W'(1);
        end
      end
    end
  end

  pbs_strobe_gen u_strb (
    .busy   (busy_q),
    .tcnt   (tcnt_q),
    .kind   (kind_q),
    .tset   (cur_set),
    .cs_act (cs_act),
    .we_act (we_act),
    .re_act (re_act),
    .dc_act (dc_act),
    .pins   (pin_vec)
  );

  assign bus_cs   = pin_vec[3];
  assign bus_we   = pin_vec[2];
  assign bus_re   = pin_vec[1];
  assign bus_dc   = pin_vec[0];
  assign bus_dout = wdata_q;
  assign bus_oe   = busy_q && (kind_q != ACC_READ);
  assign busy     = busy_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/pbs_strobe_seq_chk.sv
module pbs_strobe_seq_chk #(
  parameter int DW   = 16,
  parameter int TK_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            busy,
  input logic            rd_valid,
  input logic            tick,
  input logic            half_q,
  input logic            we_act,
  input logic            re_act,
  input logic [TK_W-1:0] tcnt,
  input logic [DW-1:0]   bus_dout
);

  // R2
  start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_act && re_act));

  // R3
  half_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_q && tick) |=> !tick);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(tcnt));

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(tick)) |-> (tcnt == $past(tcnt) + TK_W'(1)));

  // R9
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)));

  // R11
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_dout));

endmodule

bind pbs_strobe_seq pbs_strobe_seq_chk #(.DW(DW), .TK_W(pbs_pkg::TK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy_q),
  .rd_valid  (rd_valid_q),
  .tick      (tick_ev),
  .half_q    (cur_set.half_rate),
  .we_act    (we_act),
  .re_act    (re_act),
  .tcnt      (tcnt_q),
  .bus_dout  (bus_dout)
);

// File: tb/pbs_strobe_seq_tb.sv
module pbs_strobe_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cs_sel;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_wdata;
  logic        busy, rd_valid;
  logic [15:0] rd_data;
  logic        bus_cs, bus_we, bus_re, bus_dc, bus_oe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din;
  logic [31:0] w_on [2];
  logic [31:0] w_cyc [2];
  logic [31:0] w_cfg [2];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench copy of the programmed settings
  int p_cson [2], p_csoff [2], p_weon [2], p_weoff [2], p_reon [2], p_reoff [2];
  int p_wr [2], p_rd [2], p_pw [2], p_acc [2], p_half [2];
  logic [3:0] p_pol [2];   // {cs, we, re, dc}

  always #5 clk = ~clk;

  pbs_strobe_seq #(.DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .on_time_ch0(w_on[0]), .cyc_time_ch0(w_cyc[0]), .cfg_ch0(w_cfg[0]),
    .on_time_ch1(w_on[1]), .cyc_time_ch1(w_cyc[1]), .cfg_ch1(w_cfg[1]),
    .cs_sel(cs_sel), .req_valid(req_valid), .req_kind(req_kind), .req_wdata(req_wdata),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_dc(bus_dc),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic lvl(input logic pol, input logic active);
    if (pol) return active;
    return !active;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_chan(input int ch, input int cson, input int csoff,
                          input int weon, input int weoff, input int reon, input int reoff,
                          input int wr, input int rd, input int pw, input int acc,
                          input int half, input logic [3:0] pol);
    p_cson[ch] = cson; p_csoff[ch] = csoff; p_weon[ch] = weon; p_weoff[ch] = weoff;
    p_reon[ch] = reon; p_reoff[ch] = reoff; p_wr[ch] = wr; p_rd[ch] = rd;
    p_pw[ch] = pw; p_acc[ch] = acc; p_half[ch] = half; p_pol[ch] = pol;
    w_on[ch]  = 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14)
              | (32'(reon) << 20) | (32'(reoff) << 24);
    w_cyc[ch] = 32'(wr) | (32'(rd) << 6) | (32'(pw) << 12) | (32'(acc) << 22);
    w_cfg[ch] = (32'(half) << 4) | (32'(pol) << 16);
  endtask

  task automatic redrive_chan(input int ch);
    set_chan(ch, p_cson[ch], p_csoff[ch], p_weon[ch], p_weoff[ch], p_reon[ch], p_reoff[ch],
             p_wr[ch], p_rd[ch], p_pw[ch], p_acc[ch], p_half[ch], p_pol[ch]);
  endtask

  // one access, checked on every clock against the bench model
  task automatic run_access(input int kind, input int sel, input logic [15:0] wd,
                            input bit disturb, input string xtag);
    int ch, dv, ce, e, last, t;
    bit busy_e, wr, cs_l, we_l, re_l, dc_l;
    ch = sel - 1;
    dv = (p_half[ch] != 0) ? 2 : 1;
    wr = (kind != 2);
    ce = imax(p_csoff[ch], p_cson[ch] + p_pw[ch]);
    e  = imax(wr ? p_wr[ch] : p_rd[ch], ce);
    if (!wr) e = imax(e, p_acc[ch] + 1);
    last = e * dv;
    @(negedge clk);
    cs_sel = 2'(sel); req_kind = 2'(kind); req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    for (int n = 0; n <= last + 1; n++) begin
      @(negedge clk);
      if (!disturb && n == 0) req_valid = 1'b0;
      if (disturb) begin
        req_wdata = ~wd;
        if (n == 1) begin
          w_on[ch] = ~w_on[ch]; w_cyc[ch] = ~w_cyc[ch]; w_cfg[ch] = ~w_cfg[ch];
        end
        if (n == last - 1) req_valid = 1'b0;
      end
      busy_e = (n < last);
      t = n / dv;
      cs_l = busy_e && t >= p_cson[ch] && t < ce;
      we_l = busy_e && wr && t >= p_weon[ch] && t < p_weoff[ch];
      re_l = busy_e && !wr && t >= p_reon[ch] && t < p_reoff[ch];
      dc_l = busy_e && kind == 0;
      chk({"R8", xtag}, $sformatf("busy n=%0d", n), 32'(busy), 32'(busy_e));
      chk({"R4/R7", xtag}, $sformatf("cs n=%0d", n), 32'(bus_cs), 32'(lvl(p_pol[ch][3], cs_l)));
      chk({"R5/R7", xtag}, $sformatf("we n=%0d", n), 32'(bus_we), 32'(lvl(p_pol[ch][2], we_l)));
      chk({"R5/R7", xtag}, $sformatf("re n=%0d", n), 32'(bus_re), 32'(lvl(p_pol[ch][1], re_l)));
      chk({"R6/R7", xtag}, $sformatf("dc n=%0d", n), 32'(bus_dc), 32'(lvl(p_pol[ch][0], dc_l)));
      chk({"R11", xtag}, $sformatf("oe n=%0d", n), 32'(bus_oe), 32'(busy_e && wr));
      if (busy_e && wr) chk({"R11", xtag}, $sformatf("dout n=%0d", n), 32'(bus_dout), 32'(wd));
      chk({"R9", xtag}, $sformatf("rd_valid n=%0d", n), 32'(rd_valid), 32'(!wr && n == last));
      bus_din = 16'hA500 + 16'(n);
    end
    if (!wr) chk({"R9", xtag}, "rd_data", 32'(rd_data),
                 32'(16'hA500 + 16'(p_acc[ch] * dv + dv - 1)));
    if (disturb) begin
      chk("R2", "dout after ignored request", 32'(bus_dout), 32'(wd));
      redrive_chan(ch);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 32'd0);
    chk("R1", "cs in reset", 32'(bus_cs), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
    chk("R1", "pins cs/we/re/dc", 32'({bus_cs, bus_we, bus_re, bus_dc}), 32'hF);
    chk("R1", "oe", 32'(bus_oe), 32'd0);
  endtask

  task automatic t_bad_request;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      cs_sel    = (k == 0) ? 2'd0 : ((k == 1) ? 2'd3 : 2'd1);
      req_kind  = (k == 2) ? 2'd3 : 2'd1;
      req_wdata = 16'hDEAD;
      req_valid = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R2", $sformatf("busy on rejected request %0d", k), 32'(busy), 32'd0);
        chk("R2", $sformatf("cs on rejected request %0d", k), 32'(bus_cs), 32'd1);
        chk("R2", $sformatf("dout on rejected request %0d", k), 32'(bus_dout), 32'd0);
      end
      req_valid = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0; cs_sel = 2'd0; req_valid = 1'b0; req_kind = 2'd0;
    req_wdata = 16'h0; bus_din = 16'h0;
    set_chan(0, 1, 8, 2, 6, 2, 7, 9, 10, 3, 5, 0, 4'b0000);
    set_chan(1, 0, 5, 1, 4, 1, 5, 5, 6, 2, 3, 1, 4'b1010);
    t_reset();
    t_bad_request();
    // command write, channel 0, full rate
    run_access(0, 1, 16'h1234, 1'b0, "");
    // data write, channel 1, half rate, mixed polarity
    run_access(1, 2, 16'h5A5A, 1'b0, "/R3/R10");
    // read on channel 0
    run_access(2, 1, 16'h0, 1'b0, "");
    // read on channel 1 at half rate
    run_access(2, 2, 16'h0, 1'b0, "/R3");
    // CS minimum width extends chip select and the cycle
    set_chan(0, 2, 6, 3, 5, 3, 6, 6, 7, 9, 4, 0, 4'b0101);
    run_access(0, 1, 16'hC0DE, 1'b0, "");
    run_access(2, 1, 16'h0, 1'b0, "");
    // access time beyond read cycle length, half rate
    set_chan(1, 1, 7, 2, 5, 2, 6, 7, 6, 1, 9, 1, 4'b1111);
    run_access(2, 2, 16'h0, 1'b0, "/R3");
    // request and channel words disturbed during the access
    run_access(1, 1, 16'h7E81, 1'b1, "/R10");
    run_access(2, 2, 16'h0, 1'b1, "/R10");
    repeat (2) @(negedge clk);
    chk("R2", "idle after disturbed accesses", 32'(busy), 32'd0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule